// File: doc/BRIEF.md
# Tile-Composed Multi-Precision Multiplier

This block forms unsigned products from an array of identical small square multiplier tiles. Each operand is cut into tile-wide chunks. Every pair of chunks is multiplied in its own tile. Each partial product is then moved left by the summed weights of its two chunks, and all of them are added. The result is the product of the full operands.

A two-bit precision mode divides the same tile array in a different way at run time. In full mode every tile contributes, and the result is one wide product. In half mode the operands are treated as two independent lanes. In quarter mode they are four lanes. For the narrow modes only the tiles whose chunks both fall in the same lane stay enabled. The other tiles have their inputs forced to zero. Each lane product then falls into its own field of the result with no overlap, so the same adder serves every mode.

The tile width (`TILE_W`) and the number of chunks per operand (`N_CHUNK`) are parameters. `N_CHUNK` must be a multiple of four. With the defaults, 4-bit tiles and 4 chunks, the block takes 16-bit operands and gives a 32-bit result. Setting 8-bit tiles gives 32-bit operands and a 64-bit result. The result is captured in a single output register.

Top module: `tilemul`

## Requirements
- R1: With `mode_i` = 2'b00, `prod_o` holds the full unsigned product `a_i * b_i` (16x16 into 32 bits at default parameters).
- R2: With `mode_i` = 2'b01, `prod_o[15:0]` = `a_i[7:0] * b_i[7:0]` and `prod_o[31:16]` = `a_i[15:8] * b_i[15:8]`.
- R3: With `mode_i` = 2'b10, for each k in 0..3, `prod_o[8k+7:8k]` = `a_i[4k+3:4k] * b_i[4k+3:4k]`.
- R4: `mode_i` = 2'b11 gives the same result as full mode.
- R5: `valid_o` equals `valid_i` delayed by one clock. The `prod_o` shown while `valid_o` is high belongs to the operands and mode sampled on that same edge.
- R6: While `valid_i` is low, `prod_o` holds its last value, whatever the operands or mode do.
- R7: An active-low `rst_ni` clears `valid_o` and `prod_o` to zero asynchronously.
- R8: In the half and quarter modes the lanes are independent. Operand bits outside a lane never change that lane's result, so cross-lane chunk pairs contribute zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and mode are valid this cycle |
| mode_i | input | 2 | Precision: 00 full, 01 two lanes, 10 four lanes, 11 full |
| a_i | input | TILE_W*N_CHUNK | Multiplicand |
| b_i | input | TILE_W*N_CHUNK | Multiplier |
| valid_o | output | 1 | Result valid |
| prod_o | output | 2*TILE_W*N_CHUNK | Product, or the packed lane products |

## Verification
Every product, and `valid_o`, is due exactly one clock after the edge that samples `valid_i` high. The bench drives operands on a falling edge and lets one rising edge pass. It reads the outputs on the next falling edge, so no sample lands on an edge where they change. For the hold checks, the bench drives new operands with `valid_i` low and reads one falling edge later. That is the first point at which a wrongly loaded register would show. For the reset check, the bench reads a moment after `rst_ni` falls, because the clear does not wait for a clock.

// File: rtl/tilemul_pkg.sv
package tilemul_pkg;

  typedef enum logic [1:0] {
    MODE_FULL    = 2'b00,
    MODE_HALF    = 2'b01,
    MODE_QUARTER = 2'b10,
    MODE_ALTFULL = 2'b11
  } mode_e;

  // chunk pair (i,j) contributes only when both chunks sit in one lane
  function automatic logic pair_enabled(mode_e m, int i, int j, int n);
    int grp;
    case (m)
      MODE_HALF:    grp = n / 2;
      MODE_QUARTER: grp = n / 4;
      default:      grp = n;
    endcase
    return (i / grp) == (j / grp);
  endfunction

endpackage

// File: rtl/tilemul_tile.sv
module tilemul_tile #(
  parameter int TILE_W = 4
) (
  input  logic [TILE_W-1:0]   a_i,
  input  logic [TILE_W-1:0]   b_i,
  input  logic                en_i,
  output logic [2*TILE_W-1:0] p_o
);
  logic [TILE_W-1:0] a_g, b_g;

  // operand gating keeps disabled tiles quiet
  assign a_g = en_i ? a_i : '0;
  assign b_g = en_i ? b_i : '0;
  assign p_o = (2*TILE_W)'(a_g) * (2*TILE_W)'(b_g);
endmodule

// File: rtl/tilemul_array.sv
module tilemul_array
  import tilemul_pkg::*;
#(
  parameter int TILE_W  = 4,
  parameter int N_CHUNK = 4,
  localparam int OP_W   = TILE_W * N_CHUNK,
  localparam int N_PAIR = N_CHUNK * N_CHUNK
) (
  input  logic [OP_W-1:0]                  a_i,
  input  logic [OP_W-1:0]                  b_i,
  input  mode_e                            mode_i,
  output logic [N_PAIR-1:0][2*TILE_W-1:0]  pp_o
);
  for (genvar i = 0; i < N_CHUNK; i++) begin : g_a
    for (genvar j = 0; j < N_CHUNK; j++) begin : g_b
      logic en;
      assign en = pair_enabled(mode_i, i, j, N_CHUNK);
      tilemul_tile #(.TILE_W(TILE_W)) u_tile (
        .a_i (a_i[i*TILE_W +: TILE_W]),
        .b_i (b_i[j*TILE_W +: TILE_W]),
        .en_i(en),
        .p_o (pp_o[i*N_CHUNK + j])
      );
    end
  end
endmodule

// File: rtl/tilemul_sum.sv
module tilemul_sum #(
  parameter int TILE_W  = 4,
  parameter int N_CHUNK = 4,
  localparam int RES_W  = 2 * TILE_W * N_CHUNK,
  localparam int N_PAIR = N_CHUNK * N_CHUNK
) (
  input  logic [N_PAIR-1:0][2*TILE_W-1:0] pp_i,
  output logic [RES_W-1:0]                sum_o
);
  // weight of pair (i,j) is (i+j) tiles; same adder serves every mode
  always_comb begin
    sum_o = '0;
    for (int k = 0; k < N_PAIR; k++) begin
      sum_o = sum_o + (RES_W'(pp_i[k]) << ((k / N_CHUNK + k % N_CHUNK) * TILE_W));
    end
  end
endmodule

// File: rtl/tilemul.sv
module tilemul
  import tilemul_pkg::*;
#(
  parameter int TILE_W  = 4,
  parameter int N_CHUNK = 4,
  localparam int OP_W   = TILE_W * N_CHUNK,
  localparam int RES_W  = 2 * OP_W,
  localparam int N_PAIR = N_CHUNK * N_CHUNK
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       mode_i,
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  output logic             valid_o,
  output logic [RES_W-1:0] prod_o
);
  logic [N_PAIR-1:0][2*TILE_W-1:0] pp;
  logic [RES_W-1:0]                sum;

  tilemul_array #(.TILE_W(TILE_W), .N_CHUNK(N_CHUNK)) u_array (
    .a_i   (a_i),
    .b_i   (b_i),
    .mode_i(mode_e'(mode_i)),
    .pp_o  (pp)
  );

  tilemul_sum #(.TILE_W(TILE_W), .N_CHUNK(N_CHUNK)) u_sum (
    .pp_i (pp),
    .sum_o(sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      prod_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) prod_o <= sum;
    end
  end
endmodule

// File: rtl/tilemul_chk.sv
module tilemul_chk #(
  parameter int TILE_W  = 4,
  parameter int N_CHUNK = 4,
  localparam int OP_W   = TILE_W * N_CHUNK,
  localparam int RES_W  = 2 * OP_W,
  localparam int HW     = OP_W / 2,
  localparam int QW     = OP_W / 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [1:0]       mode_i,
  input logic [OP_W-1:0]  a_i,
  input logic [OP_W-1:0]  b_i,
  input logic             valid_o,
  input logic [RES_W-1:0] prod_o
);
  // R1
  full_prod_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'b00) |=> prod_o == RES_W'($past(a_i)) * RES_W'($past(b_i)));

  // R4
  alt_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'b11) |=> prod_o == RES_W'($past(a_i)) * RES_W'($past(b_i)));

  // R2
  half_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'b01) |=>
      prod_o[OP_W-1:0] == OP_W'($past(a_i[HW-1:0])) * OP_W'($past(b_i[HW-1:0])));

  // R2
  half_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'b01) |=>
      prod_o[RES_W-1:OP_W] == OP_W'($past(a_i[OP_W-1:HW])) * OP_W'($past(b_i[OP_W-1:HW])));

  // R3
  quarter_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'b10) |=>
      prod_o[HW-1:0] == HW'($past(a_i[QW-1:0])) * HW'($past(b_i[QW-1:0])));

  // R3
  quarter_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'b10) |=>
      prod_o[RES_W-1:RES_W-HW] == HW'($past(a_i[OP_W-1:OP_W-QW])) * HW'($past(b_i[OP_W-1:OP_W-QW])));

  // R5
  valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R5
  valid_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(prod_o));

  // R7
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      reset_clear_chk: assert (!valid_o && prod_o == '0);
    end
  end
endmodule

bind tilemul tilemul_chk #(.TILE_W(TILE_W), .N_CHUNK(N_CHUNK)) u_chk (.*);

// File: tb/tilemul_test.sv
`timescale 1ns/1ps
module tilemul_test;
  localparam int OW = 16;
  localparam int RW = 32;

  typedef struct packed {
    logic [1:0]    m;
    logic [OW-1:0] a;
    logic [OW-1:0] b;
    logic [RW-1:0] e;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 16'hFFFF, 16'hFFFF, 32'hFFFE0001},
    '{2'b00, 16'h0100, 16'h0100, 32'h00010000},
    '{2'b00, 16'h8000, 16'h0002, 32'h00010000},
    '{2'b00, 16'h1234, 16'h0010, 32'h00012340},
    '{2'b01, 16'hFFFF, 16'hFFFF, 32'hFE01FE01},
    '{2'b01, 16'h0201, 16'h0302, 32'h00060002},
    '{2'b01, 16'h8080, 16'h0202, 32'h01000100},
    '{2'b10, 16'hFFFF, 16'hFFFF, 32'hE1E1E1E1},
    '{2'b10, 16'h1234, 16'h5678, 32'h050C1520},
    '{2'b10, 16'h8421, 16'hFFFF, 32'h783C1E0F},
    '{2'b11, 16'h0003, 16'h0005, 32'h0000000F}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [1:0]    mode_i = 2'b00;
  logic [OW-1:0] a_i = '0;
  logic [OW-1:0] b_i = '0;
  logic          valid_o;
  logic [RW-1:0] prod_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  tilemul uut (.*);

  always #2 clk_i = ~clk_i;

  function automatic logic [RW-1:0] ref_prod(logic [1:0] m, logic [OW-1:0] a, logic [OW-1:0] b);
    int lanes = (m == 2'b01) ? 2 : (m == 2'b10) ? 4 : 1;
    int lw = OW / lanes;
    logic [RW-1:0] r = '0;
    for (int l = 0; l < lanes; l++) begin
      logic [RW-1:0] la = RW'(a >> (l * lw)) & ((RW'(1) << lw) - 1);
      logic [RW-1:0] lb = RW'(b >> (l * lw)) & ((RW'(1) << lw) - 1);
      r = r | ((la * lb) << (2 * lw * l));
    end
    return r;
  endfunction

  task automatic check(string req, logic [RW-1:0] act, logic [RW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // drive on a falling edge, read one rising edge later
  task automatic apply(logic [1:0] m, logic [OW-1:0] a, logic [OW-1:0] b);
    @(negedge clk_i);
    mode_i = m; a_i = a; b_i = b; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [RW-1:0] held;
    repeat (3) @(negedge clk_i);
    check("R7 reset valid", RW'(valid_o), '0);
    check("R7 reset prod", prod_o, '0);
    rst_ni = 1'b1;

    // vector table, R1 R2 R3 R4
    foreach (VECS[n]) begin
      apply(VECS[n].m, VECS[n].a, VECS[n].b);
      check($sformatf("R1-4 vec %0d", n), prod_o, VECS[n].e);
    end

    // random per mode against reference
    for (int m = 0; m < 4; m++) begin
      for (int n = 0; n < 25; n++) begin
        logic [OW-1:0] ra = OW'($urandom);
        logic [OW-1:0] rb = OW'($urandom);
        apply(2'(m), ra, rb);
        check($sformatf("R1 R2 R3 R4 rand mode %0d", m), prod_o, ref_prod(2'(m), ra, rb));
      end
    end

    // corner: single set bit in each position, full mode (R1)
    for (int s = 0; s < OW; s++) begin
      apply(2'b00, OW'(1) << s, 16'hFFFF);
      check("R1 single bit", prod_o, RW'(16'hFFFF) << s);
    end

    // R5: valid timing
    @(negedge clk_i);
    mode_i = 2'b00; a_i = 16'd7; b_i = 16'd9; valid_i = 1'b1;
    check("R5 valid not early", RW'(valid_o), '0);
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R5 valid after one clock", RW'(valid_o), 32'd1);
    check("R5 product after one clock", prod_o, 32'd63);
    @(negedge clk_i);
    check("R5 valid drops", RW'(valid_o), '0);

    // R6: hold while valid_i low
    held = prod_o;
    a_i = 16'hABCD; b_i = 16'h1357; mode_i = 2'b10;
    @(negedge clk_i);
    check("R6 hold prod", prod_o, held);

    // R8: cross terms gated, lanes independent
    apply(2'b10, 16'h00F0, 16'h0F00);
    check("R8 quarter cross zero", prod_o, 32'h0);
    apply(2'b10, 16'h0003, 16'h0005);
    held = prod_o;
    apply(2'b10, 16'hF003, 16'h5005);
    check("R8 quarter lane0 unchanged", {24'h0, prod_o[7:0]}, {24'h0, held[7:0]});
    apply(2'b01, 16'h00FF, 16'hFF00);
    check("R8 half cross zero", prod_o, 32'h0);

    // R7: asynchronous reset mid-run
    apply(2'b00, 16'h1111, 16'h1111);
    #1 rst_ni = 1'b0;
    #0.5;
    check("R7 async clear prod", prod_o, '0);
    check("R7 async clear valid", RW'(valid_o), '0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule